// File: doc/BRIEF.md
# ADC Frame Builder with CRC

This block gathers one sample from each of eight ADC channels and builds one 120-bit frame from them every frame period. A downstream parallel-to-serial stage takes the frame as four 30-bit words on a clock that runs at four times the frame rate. At 40 MHz frames this is a 160 MHz word clock and a 4.8 Gbps line. Every frame opens with an 8-bit header. The header's upper nibble is a fixed marker, and its lower nibble comes from a 7-bit LFSR that steps once per frame, so the receiver can check word alignment and frame continuity.

A mode input picks one of two layouts for the remaining 112 bits. In data mode the frame carries eight 12-bit samples (96 bits), followed by a 16-bit CRC computed over them. In calibration mode the CRC slot is given to the payload, which then carries eight full 14-bit samples. The block reads its inputs only on the word-clock edge that loads a new frame. The mode and the samples may therefore change freely at any other time.

Top module: `adc_frame_builder`

## Requirements
- R1: While `rst` is high at a rising edge, `word_o` goes to zero and `sof_o` goes low. After `rst` falls, the first rising edge loads a frame.
- R2: A frame is loaded every fourth rising edge. On the loading edge `sof_o` rises and `word_o` shows frame bits [119:90]. On the next three edges `sof_o` is low and `word_o` shows bits [89:60], [59:30] and [29:0], in that order.
- R3: Frame bits [119:116] are always 4'b0101.
- R4: Frame bits [115:112] are the low four bits of a 7-bit LFSR. The LFSR steps as s_next = {s[5:0], s[6]^s[5]} once per frame. It holds the seed 7'h5A for the first frame after reset.
- R5: In data mode (`cal_mode_i` = 0), frame bits [111:16] carry eight 12-bit samples. Channel 0 is in the highest 12 bits, channel 7 in the lowest, and each sample is MSB first. On `samples_i`, channel c occupies bits [111-14c : 98-14c], and its sample is the low 12 bits of that slot.
- R6: In data mode, frame bits [15:0] hold a CRC-16 of frame bits [111:16]. The CRC uses polynomial 0x1021 and initial value 0xFFFF, and it takes the bits MSB first with no reflection and no final XOR.
- R7: In calibration mode (`cal_mode_i` = 1), frame bits [111:0] equal `samples_i` unchanged. Each channel is carried as 14 bits and no CRC is sent.
- R8: `cal_mode_i` is sampled only on a loading edge. A change at any other edge does not alter the frame being sent.
- R9: `samples_i` is sampled only on a loading edge. A change at any other edge does not alter the frame being sent.
- R10: In data mode, the upper two bits of each 14-bit input slot have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, four times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| cal_mode_i | input | 1 | 0 = data mode with CRC, 1 = calibration mode |
| samples_i | input | 112 | Eight 14-bit sample slots, channel 0 in the top slot |
| word_o | output | 30 | Frame word to the serializer, registered |
| sof_o | output | 1 | High with the first (header) word of each frame |

## Verification
Each frame's inputs are taken on the loading edge, and the header word appears on `word_o` right after that same edge. The three later words follow on the next three edges, one per edge. The bench therefore sets the inputs at the falling edge before a loading edge and pushes the four expected words into a queue. A monitor pops one entry at each falling edge, which is half a cycle after the edge that updated the output. Between loading edges the driver inverts the mode and the samples; because the expected words were computed from the values held at the loading edge, any leak of those changes shows up as a mismatch. A reset in the middle of the run, with a frame following it, checks that the LFSR returns to its seed.

// File: rtl/adcfb_pkg.sv
package adcfb_pkg;
  localparam int unsigned CH_N       = 8;
  localparam int unsigned SLOT_W     = 14;
  localparam int unsigned DATA_W     = 12;
  localparam int unsigned CRC_W      = 16;
  localparam int unsigned HDR_W      = 8;
  localparam int unsigned MARK_W     = 4;
  localparam int unsigned WORD_W     = 30;
  localparam int unsigned WORDS      = 4;
  localparam int unsigned PRBS_W     = 7;
  localparam int unsigned FRAME_W    = WORD_W * WORDS;
  localparam logic [3:0]  HDR_MARK   = 4'b0101;
  localparam logic [6:0]  PRBS_SEED  = 7'h5A;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;

  typedef enum logic {
    MODE_DATA = 1'b0,
    MODE_CAL  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/adcfb_prbs.sv
module adcfb_prbs #(
  parameter int unsigned W     = 7,
  parameter int unsigned OUT_W = 4,
  parameter int unsigned TAP_A = 6,
  parameter int unsigned TAP_B = 5,
  parameter logic [W-1:0] SEED = 7'h5A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [OUT_W-1:0] bits_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)        state_q <= SEED;
    else if (adv_i) state_q <= {state_q[W-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
  end

  assign bits_o = state_q[OUT_W-1:0];

  // R4: the sequence never falls into the all-zero lock-up state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  // R4: one step per frame, no motion in between
  a_r4_lfsr_steps: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> state_q != $past(state_q));
  a_r4_lfsr_holds: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(state_q));
endmodule

// File: rtl/adcfb_crc.sv
module adcfb_crc #(
  parameter int unsigned  DATA_W = 96,
  parameter int unsigned  CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // Bit-serial definition unrolled into one combinational cone, MSB first
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ data_i[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = acc;
  end
endmodule

// File: rtl/adcfb_packer.sv
module adcfb_packer #(
  parameter int unsigned CH_N    = 8,
  parameter int unsigned SLOT_W  = 14,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned HDR_W   = 8,
  parameter int unsigned CRC_W   = 16,
  parameter int unsigned FRAME_W = 120,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic [HDR_W-1:0]       hdr_i,
  input  logic [CH_N*SLOT_W-1:0] samples_i,
  input  logic                   cal_i,
  output logic [FRAME_W-1:0]     frame_o
);
  localparam int unsigned PL_W = CH_N * DATA_W;

  logic [PL_W-1:0]  data_pl;
  logic [CRC_W-1:0] crc;

  // Slot position p holds channel CH_N-1-p; the same position carries over
  // to the narrow payload, so channel 0 stays at the top.
  for (genvar p = 0; p < CH_N; p++) begin : g_slot
    assign data_pl[p*DATA_W +: DATA_W] = samples_i[p*SLOT_W +: DATA_W];
  end

  adcfb_crc #(
    .DATA_W(PL_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)
  ) u_crc (
    .data_i(data_pl),
    .crc_o (crc)
  );

  always_comb begin
    if (cal_i) frame_o = {hdr_i, samples_i};
    else       frame_o = {hdr_i, data_pl, crc};
  end
endmodule

// File: rtl/adcfb_serout.sv
module adcfb_serout #(
  parameter int unsigned WORD_W  = 30,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned FRAME_W = 120
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               load_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               sof_o
);
  localparam int unsigned CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;

  assign load_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LAST;
      sh_q  <= '0;
      sof_o <= 1'b0;
    end else if (load_o) begin
      cnt_q <= '0;
      sh_q  <= frame_i;
      sof_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[FRAME_W-WORD_W-1:0], {WORD_W{1'b0}}};
      sof_o <= 1'b0;
    end
  end

  assign word_o = sh_q[FRAME_W-1 -: WORD_W];

  // R2: strobe follows every load and nothing else
  a_r2_sof_after_load: assert property (@(posedge clk) disable iff (rst)
    load_o |=> sof_o);
  a_r2_no_stray_sof: assert property (@(posedge clk) disable iff (rst)
    !load_o |=> !sof_o);
  a_r2_sof_single: assert property (@(posedge clk) disable iff (rst)
    sof_o |=> !sof_o);
endmodule

// File: rtl/adc_frame_builder.sv
module adc_frame_builder
  import adcfb_pkg::*;
#(
  parameter int unsigned P_CH_N   = CH_N,
  parameter int unsigned P_SLOT_W = SLOT_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_WORD_W = WORD_W,
  parameter int unsigned P_WORDS  = WORDS,
  parameter logic [PRBS_W-1:0] P_SEED = PRBS_SEED
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cal_mode_i,
  input  logic [P_CH_N*P_SLOT_W-1:0] samples_i,
  output logic [P_WORD_W-1:0]        word_o,
  output logic                       sof_o
);
  localparam int unsigned F_W   = P_WORD_W * P_WORDS;
  localparam int unsigned PRN_W = HDR_W - MARK_W;

  logic             load;
  logic [PRN_W-1:0] prn;
  logic [F_W-1:0]   frame;
  frame_mode_e      mode;

  assign mode = frame_mode_e'(cal_mode_i);

  adcfb_prbs #(
    .W(PRBS_W), .OUT_W(PRN_W), .TAP_A(6), .TAP_B(5), .SEED(P_SEED)
  ) u_prbs (
    .clk(clk), .rst(rst), .adv_i(load), .bits_o(prn)
  );

  adcfb_packer #(
    .CH_N(P_CH_N), .SLOT_W(P_SLOT_W), .DATA_W(P_DATA_W), .HDR_W(HDR_W),
    .CRC_W(CRC_W), .FRAME_W(F_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
  ) u_pack (
    .hdr_i    ({HDR_MARK, prn}),
    .samples_i(samples_i),
    .cal_i    (mode == MODE_CAL),
    .frame_o  (frame)
  );

  adcfb_serout #(
    .WORD_W(P_WORD_W), .WORDS(P_WORDS), .FRAME_W(F_W)
  ) u_ser (
    .clk(clk), .rst(rst), .frame_i(frame),
    .load_o(load), .word_o(word_o), .sof_o(sof_o)
  );

  // R3: every header word carries the fixed marker
  a_r3_header_mark: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> word_o[P_WORD_W-1 -: MARK_W] == HDR_MARK);
endmodule

// File: tb/adc_frame_builder_test.sv
`timescale 1ns/1ps
module adc_frame_builder_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cal_mode = 1'b0;
  logic [111:0] smp = '0;
  logic [29:0]  word;
  logic         sof;

  int n_run = 0;
  int n_fail = 0;
  bit active = 1'b0;
  logic [6:0] ref_prn = 7'h5A;

  logic [29:0] q_w[$];
  logic        q_s[$];
  string       q_t[$];

  always #2.5 clk = ~clk;

  adc_frame_builder uut (
    .clk(clk), .rst(rst), .cal_mode_i(cal_mode), .samples_i(smp),
    .word_o(word), .sof_o(sof)
  );

  function automatic logic [15:0] ref_crc(input logic [95:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 95; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [119:0] ref_frame(input logic cal, input logic [111:0] s,
                                             input logic [3:0] prn);
    logic [95:0] pl;
    for (int c = 0; c < 8; c++) pl[95-12*c -: 12] = s[111-14*c -: 14] & 14'h0FFF;
    if (cal) return {4'b0101, prn, s};
    return {4'b0101, prn, pl, ref_crc(pl)};
  endfunction

  function automatic logic [111:0] pattern(input int k, input logic [13:0] base);
    logic [111:0] s;
    for (int c = 0; c < 8; c++) s[111-14*c -: 14] = base + 14'(c * (37 + k)) + 14'(k * 911);
    return s;
  endfunction

  task automatic check(input string tag, input logic [29:0] aw, input logic [29:0] ew,
                       input logic as, input logic es);
    n_run++;
    if (aw !== ew || as !== es) begin
      n_fail++;
      $display("FAIL %s: got word=%h sof=%b expected word=%h sof=%b", tag, aw, as, ew, es);
    end
  endtask

  // Driver: call at a falling edge one cycle before a loading edge
  task automatic send_frame(input logic cal, input logic [111:0] s,
                            input string tag, input bit scramble);
    logic [119:0] f;
    cal_mode = cal;
    smp = s;
    f = ref_frame(cal, s, ref_prn[3:0]);
    ref_prn = {ref_prn[5:0], ref_prn[6] ^ ref_prn[5]};
    for (int k = 0; k < 4; k++) begin
      q_w.push_back(f[119-30*k -: 30]);
      q_s.push_back(k == 0);
      q_t.push_back($sformatf("%s w%0d", tag, k));
    end
    if (!active) begin
      @(posedge clk);
      active = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (scramble && i < 3) begin
        cal_mode = ~cal;
        smp = ~s ^ {8{14'h1555}};
      end
    end
  endtask

  // Monitor: one expected word per falling edge while frames are due
  initial begin
    forever begin
      @(negedge clk);
      if (active) begin
        if (q_w.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R2: output word %h with nothing expected", word);
        end else begin
          check(q_t.pop_front(), word, q_w.pop_front(), sof, q_s.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", word, 30'h0, sof, 1'b0);
    rst = 1'b0;
    send_frame(1'b0, pattern(0, 14'h0123), "R1/R2/R3/R4/R5/R6 first data", 1'b0);
    send_frame(1'b1, pattern(1, 14'h2ABC), "R7 cal", 1'b0);
    send_frame(1'b0, {8{14'h3FFF}}, "R10/R5/R6 all ones slots", 1'b0);
    send_frame(1'b0, {8{14'h3000}}, "R10 upper bits only", 1'b0);
    send_frame(1'b1, '0, "R7 cal zeros", 1'b0);
    send_frame(1'b0, pattern(2, 14'h0F0F), "R8/R9 data scrambled", 1'b1);
    send_frame(1'b1, pattern(3, 14'h1234), "R8/R9 cal scrambled", 1'b1);
    for (int k = 4; k < 20; k++)
      send_frame(1'(k % 3 == 0), pattern(k, 14'(k * 77)), "R4/R5/R6/R7 walk", 1'(k % 2));
    wait (q_w.size() == 0);
    active = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", word, 30'h0, sof, 1'b0);
    rst = 1'b0;
    ref_prn = 7'h5A;
    send_frame(1'b0, pattern(30, 14'h0777), "R1/R4 reseed", 1'b0);
    send_frame(1'b0, pattern(31, 14'h0555), "R4 after reseed", 1'b0);
    wait (q_w.size() == 0);
    active = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule